// File: doc/BRIEF.md
# Halving tree sum reducer

This block folds N signed partial sums into a single total. A start strobe captures all N values in parallel into a bank of accumulators, one per participant. The block then runs a sequence of halving rounds. In each round the active range is cut at a rounded-up midpoint. Every participant above the cut passes its value down to the participant sitting exactly one cut-width below it, and that participant adds the value to its own.

When the active count is odd, the participant at the middle neither sends nor adds. It becomes the highest member of the next, smaller range. Once the cut reaches one, participant 0 holds the total. The block then raises a one-cycle completion pulse and holds the total until the next reduction finishes.

One round takes one clock cycle. All adds in a round read the values the bank held before that round. A design that needs a wide sum of many registered values, with latency logarithmic in N, starts the block and waits for the pulse.

Top module: `halving_sum_reducer`

## Requirements
- R1: While rst_n is low at a rising clock edge, busy, done and total are all cleared to zero.
- R2: A start seen high while busy is low loads participant i from part_in bits [i*W +: W], taken as signed two's complement, and busy is high in the next cycle.
- R3: Each round moves the range limit L to H = ceil(L/2); participants below floor(L/2) add the value of the participant H places above them, so for odd L the middle one is idle; the run lasts as many rounds as halvings take N down to 1 (one round when N is 1, seven when N is 100), and done is high in the cycle following the last round's edge.
- R4: total equals the exact signed sum of all N loaded values, in W + clog2(N) bits, for every N including odd values and 1.
- R5: done is high for exactly one cycle per reduction.
- R6: total changes only on the clock edge that raises done; between those edges it holds, whatever part_in does.
- R7: A start that arrives while busy is high is ignored: the running reduction keeps its data, its round count and its result.
- R8: busy stays high from the cycle after the accepting edge up to the edge that raises done, and is low while done is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to load part_in and begin a reduction |
| part_in | input | N*W | N signed partial sums, participant i at bits [i*W +: W] |
| busy | output | 1 | High while rounds are running |
| done | output | 1 | One-cycle pulse when the total is ready |
| total | output | W+clog2(N) | Signed final sum, held between reductions |

## Verification
The checker watches the control behaviour on every cycle. It checks that done lasts exactly one cycle and that busy only falls together with done. It checks that an accepted start always raises busy, that a start arriving mid-run never resets the round count, that the round count equals the expected number of halvings at completion, and that total never moves outside the done edge.

The arithmetic cannot be seen from cycle-level properties. Correct summation, with the idle middle participant on odd ranges, is shown only by the bench scenarios. These compare total against a plain sequential sum for N of 1, 2, 7, 13 and 100, using extreme, patterned and random operands. The same goes for a mid-run start carrying different data, which must leave the result unchanged.

// File: rtl/hsr_pkg.sv
`timescale 1ns/1ps
// hsr_pkg: sizing helpers shared by the halving sum reducer and its checker.
// Assumes n >= 1 in every function.
package hsr_pkg;

    // Width able to hold any range limit 0..n.
    function automatic int hsr_cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    // Width of an index into n participants.
    function automatic int hsr_idx_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    // Number of rounded-up halvings from n down to one (at least one round).
    function automatic int hsr_rounds(input int n);
        int h;
        int r;
        h = n;
        r = 0;
        do begin
            h = (h + 1) / 2;
            r++;
        end while (h != 1);
        return r;
    endfunction

endpackage

// File: rtl/hsr_ctrl.sv
`timescale 1ns/1ps
// hsr_ctrl: round sequencer for the halving sum reducer.
// Keeps the moving upper limit and a round counter. From the limit it derives
// the rounded-up cut (new_half) and the number of receiving participants
// (recv_cnt). A start is accepted only while idle. Assumes N >= 1.
module hsr_ctrl #(
    parameter int N  = 100,
    parameter int CW = hsr_pkg::hsr_cnt_w(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          step,
    output logic          last,
    output logic          busy,
    output logic          done,
    output logic [CW:0]   new_half,
    output logic [CW:0]   recv_cnt,
    output logic [CW-1:0] rnd
);
    logic [CW-1:0] limit_q;
    logic [CW:0]   lim_x;

    // Cut point and receiver count for the round that runs this cycle.
    always_comb begin
        lim_x    = {1'b0, limit_q};
        new_half = (lim_x + (CW+1)'(1)) >> 1;
        recv_cnt = lim_x - new_half;
        last     = (new_half == (CW+1)'(1));
        load     = start && !busy;
        step     = busy;
    end

    // Sequencer state: accept, advance the limit each round, finish with a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            limit_q <= '0;
            rnd     <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy    <= 1'b1;
                limit_q <= CW'(N);
                rnd     <= '0;
            end else if (busy) begin
                limit_q <= new_half[CW-1:0];
                rnd     <= rnd + CW'(1);
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hsr_bank.sv
`timescale 1ns/1ps
// hsr_bank: N signed accumulators with one adder per participant.
// In a round, participant p adds the value of participant p + new_half when
// p < recv_cnt; all adds read the values registered before the round.
// lane0_next is participant 0's value after the current round.
// Assumes recv_cnt <= N - new_half, as hsr_ctrl guarantees.
module hsr_bank #(
    parameter int N     = 100,
    parameter int W     = 16,
    parameter int SUM_W = W + $clog2(N),
    parameter int CW    = hsr_pkg::hsr_cnt_w(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    step,
    input  logic [N*W-1:0]          part_in,
    input  logic [CW:0]             new_half,
    input  logic [CW:0]             recv_cnt,
    output logic signed [SUM_W-1:0] lane0_next
);
    localparam int IXW = hsr_pkg::hsr_idx_w(N);

    logic signed [SUM_W-1:0] acc  [N];
    logic signed [SUM_W-1:0] nxt  [N];
    logic signed [W-1:0]     seed [N];
    logic                    take [N];

    for (genvar p = 0; p < N; p++) begin : g_lane
        logic [CW:0]             mate_idx;
        logic signed [SUM_W-1:0] mate;

        assign seed[p] = part_in[p*W +: W];

        // Pick the partner value and decide whether this lane receives.
        always_comb begin
            mate_idx = (CW+1)'(p) + new_half;
            take[p]  = ((CW+1)'(p) < recv_cnt);
            mate     = '0;
            if (take[p] && (mate_idx < (CW+1)'(N)))
                mate = acc[mate_idx[IXW-1:0]];
        end

        assign nxt[p] = take[p] ? (acc[p] + mate) : acc[p];
    end

    // Accumulator update: parallel load on start, receiving lanes add per round.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (!rst_n)
                acc[i] <= '0;
            else if (load)
                acc[i] <= SUM_W'(seed[i]);
            else if (step && take[i])
                acc[i] <= nxt[i];
        end
    end

    assign lane0_next = nxt[0];
endmodule

// File: rtl/halving_sum_reducer.sv
`timescale 1ns/1ps
// halving_sum_reducer: sums N signed partial sums with a rounded-up halving
// schedule, one round per clock. total is captured on the final round and
// held until the next reduction completes. Starts during a run are dropped.
// Assumes N >= 1 and W >= 1.
module halving_sum_reducer #(
    parameter int  N     = 100,
    parameter int  W     = 16,
    localparam int SUM_W = W + $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [N*W-1:0]   part_in,
    output logic             busy,
    output logic             done,
    output logic [SUM_W-1:0] total
);
    localparam int CW = hsr_pkg::hsr_cnt_w(N);

    logic                    load;
    logic                    step;
    logic                    last;
    logic [CW:0]             new_half;
    logic [CW:0]             recv_cnt;
    logic [CW-1:0]           rnd_q;
    logic signed [SUM_W-1:0] final_sum;

    hsr_ctrl #(.N(N), .CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .step     (step),
        .last     (last),
        .busy     (busy),
        .done     (done),
        .new_half (new_half),
        .recv_cnt (recv_cnt),
        .rnd      (rnd_q)
    );

    hsr_bank #(.N(N), .W(W), .SUM_W(SUM_W), .CW(CW)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .step       (step),
        .part_in    (part_in),
        .new_half   (new_half),
        .recv_cnt   (recv_cnt),
        .lane0_next (final_sum)
    );

    // Result register: takes participant 0's value on the last round only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            total <= '0;
        else if (step && last)
            total <= final_sum;
    end
endmodule

// File: rtl/hsr_chk.sv
`timescale 1ns/1ps
// hsr_chk: cycle-level properties of halving_sum_reducer, attached by bind.
module hsr_chk #(
    parameter int N     = 100,
    parameter int W     = 16,
    parameter int SUM_W = W + $clog2(N),
    parameter int CW    = hsr_pkg::hsr_cnt_w(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [SUM_W-1:0] total,
    input logic [CW-1:0]    rnd
);
    localparam int ROUNDS = hsr_pkg::hsr_rounds(N);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> (rnd != '0));

    // R3
    round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rnd < CW'(ROUNDS)));

    // R3
    round_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rnd == CW'(ROUNDS)));

    // R6
    total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(total));
endmodule

bind halving_sum_reducer hsr_chk #(
    .N     (N),
    .W     (W),
    .SUM_W (SUM_W),
    .CW    (hsr_pkg::hsr_cnt_w(N))
) u_hsr_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .total (total),
    .rnd   (rnd_q)
);

// File: tb/test_halving_sum_reducer.sv
`timescale 1ns/1ps
// hsr_env: runs directed and random reductions on one reducer of size N.
module hsr_env #(
    parameter int N    = 4,
    parameter int W    = 16,
    parameter int SEED = 1
) (
    input  logic clk,
    input  logic rst_n,
    output int   n_chk,
    output int   n_fail,
    output logic fin
);
    localparam int SUM_W = W + $clog2(N);

    logic             start;
    logic [N*W-1:0]   din;
    logic             busy;
    logic             done;
    logic [SUM_W-1:0] total;

    halving_sum_reducer #(.N(N), .W(W)) i_halving_sum_reducer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .part_in (din),
        .busy    (busy),
        .done    (done),
        .total   (total)
    );

    function automatic int exp_rounds(input int n);
        int h;
        int r;
        h = n;
        r = 0;
        do begin
            h = (h + 1) / 2;
            r++;
        end while (h != 1);
        return r;
    endfunction

    function automatic longint exp_sum(input logic [N*W-1:0] v);
        longint s;
        s = 0;
        for (int i = 0; i < N; i++) s += longint'($signed(v[i*W +: W]));
        return s;
    endfunction

    function automatic longint tot_val();
        return longint'($signed(total));
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s (N=%0d): actual %0d expected %0d", req, N, act, exp);
        end
    endtask

    // One reduction; when poke is set a second start with other data is
    // driven while busy and must be ignored (R7).
    task automatic reduce(input logic [N*W-1:0] v, input bit poke);
        int cyc;
        logic [SUM_W-1:0] held;
        @(negedge clk);
        din   = v;
        start = 1'b1;
        @(negedge clk);
        check("R2 busy after accepted start", longint'(busy), 1);
        if (poke) begin
            din   = ~v;
            start = 1'b1;
        end else begin
            start = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (!done) check("R8 busy during rounds", longint'(busy), 1);
        end
        check(poke ? "R7 latency with ignored start" : "R3 round count",
              longint'(cyc), longint'(exp_rounds(N)));
        check(poke ? "R7 total with ignored start" : "R4 total",
              tot_val(), exp_sum(v));
        check("R8 busy low with done", longint'(busy), 0);
        held = total;
        @(negedge clk);
        check("R5 done one cycle", longint'(done), 0);
        for (int k = 0; k < N; k++) din[k*W +: W] = W'($urandom);
        repeat (2) @(negedge clk);
        check("R6 total held", longint'($signed(total)), longint'($signed(held)));
    endtask

    initial begin
        logic [N*W-1:0] v;
        n_chk  = 0;
        n_fail = 0;
        fin    = 1'b0;
        start  = 1'b0;
        din    = '0;
        void'($urandom(SEED));
        @(negedge clk);
        @(negedge clk);
        check("R1 reset busy", longint'(busy), 0);
        check("R1 reset done", longint'(done), 0);
        check("R1 reset total", tot_val(), 0);
        wait (rst_n);
        // R4 directed corners: zeros, full positive, full negative, mixed, ramp
        v = '0;
        reduce(v, 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = {1'b0, {(W-1){1'b1}}};
        reduce(v, 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = {1'b1, {(W-1){1'b0}}};
        reduce(v, 1'b0);
        for (int i = 0; i < N; i++)
            v[i*W +: W] = (i % 2 == 0) ? {1'b0, {(W-1){1'b1}}} : {1'b1, {(W-1){1'b0}}};
        reduce(v, 1'b0);
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(i - N / 2);
        reduce(v, 1'b0);
        // Random operands, two of them with a mid-run start (R7)
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom);
            reduce(v, (t % 4) == 1);
        end
        fin = 1'b1;
    end
endmodule

// test_halving_sum_reducer: drives clock and reset, runs several sizes.
module test_halving_sum_reducer;
    logic clk;
    logic rst_n;
    int   c0, c1, c2, c3, c4;
    int   f0, f1, f2, f3, f4;
    logic d0, d1, d2, d3, d4;

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    hsr_env #(.N(100), .SEED(11)) e_n100 (.clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .fin(d0));
    hsr_env #(.N(7),   .SEED(23)) e_n7   (.clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .fin(d1));
    hsr_env #(.N(13),  .SEED(37)) e_n13  (.clk(clk), .rst_n(rst_n), .n_chk(c2), .n_fail(f2), .fin(d2));
    hsr_env #(.N(1),   .SEED(41)) e_n1   (.clk(clk), .rst_n(rst_n), .n_chk(c3), .n_fail(f3), .fin(d3));
    hsr_env #(.N(2),   .SEED(53)) e_n2   (.clk(clk), .rst_n(rst_n), .n_chk(c4), .n_fail(f4), .fin(d4));

    initial begin
        int cyc;
        int tot_chk;
        int tot_fail;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!(d0 && d1 && d2 && d3 && d4) && cyc < 100000) begin
            @(negedge clk);
            cyc++;
        end
        tot_chk  = c0 + c1 + c2 + c3 + c4;
        tot_fail = f0 + f1 + f2 + f3 + f4;
        if (!(d0 && d1 && d2 && d3 && d4)) begin
            tot_chk++;
            tot_fail++;
            $display("FAIL watchdog R3: actual %0d cycles expected fewer than %0d", cyc, 100000);
        end
        $display("== %0d vectors applied, %0d miscompares ==", tot_chk, tot_fail);
        $finish;
    end
endmodule